// File: doc/BRIEF.md
# Scaler Control and Interrupt Unit

This block is the control core of an image scaling engine. Software sees four 32-bit registers on a simple read/write bus: a control word, an interrupt mask, a pending-cause word and a timeout setup word. The control word does two things. It launches one frame on the datapath through a one-cycle pulse. It also starts a self-clearing soft reset, which software polls until it ends. The datapath reports a finished frame on `frame_done`. Its legality checkers raise per-cause strobes on `err_pulse`.

Each cause sets its own sticky bit in the pending word. Writing ones to the pending word clears those bits. A single level interrupt is high whenever a pending bit is also enabled in the mask.

A watchdog guards each frame. Its clock is divided by a power of two, and it raises a dedicated cause when the frame has not finished within a programmed number of ticks.

Register word addresses on `bus_addr`:
- 0: control. Write bit 0 to start a frame. Write bit 1 to start a soft reset. On read, bit 0 is busy and bit 1 is reset in progress.
- 1: interrupt mask.
- 2: pending causes.
- 3: timeout setup. Bits 15:0 are the tick limit, bits 19:16 are the divider exponent and bit 31 is the enable.

Pending and mask bit layout: bit 0 is frame end, bit 1 is timeout, and bits 2 upward are the error strobes `err_pulse[0]` upward.

Top module: `scaler_ctrl`

## Requirements
- R1: After the reset input is released, control, mask and pending read 0. Timeout setup reads 0x800F_FFFF. `irq`, `busy` and `frame_start` are 0.
- R2: Writing bit 1 of control makes bit 1 read 1 for exactly RST_CYCLES clock edges, after which it reads 0. The write ends any running frame and clears the pending word and the mask.
- R3: Mask writes made while the soft reset is in progress are ignored. Once it ends, a mask write reads back as the written value masked to NUM_ERR+2 bits.
- R4: Writing bit 0 of control while idle and not resetting sets `busy` and gives `frame_start` high for exactly one cycle. A start written while busy gives no pulse.
- R5: `frame_done` while busy sets pending bit 0 and clears `busy`. `frame_done` while idle has no effect.
- R6: A strobe on `err_pulse[i]` sets pending bit i+2 and does not end the frame.
- R7: Writing the pending word clears exactly the bits written as 1. A cause arriving in the same cycle as its clear leaves the bit set.
- R8: `irq` is high exactly when some pending bit has its mask bit set. A zero mask keeps `irq` low.
- R9: With the timeout enabled, limit V and divider D, a frame still busy (V+1)·2^D edges after its start edge sets pending bit 1 on that edge and clears `busy`. A frame that finishes earlier sets no timeout.
- R10: With the timeout enable bit clear, a busy frame never times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational on address) |
| frame_done | input | 1 | Datapath frame-finished pulse |
| err_pulse | input | NUM_ERR | Per-cause error strobes from the checkers |
| frame_start | output | 1 | One-cycle launch pulse to the datapath |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with NUM_ERR = 6 and RST_CYCLES = 5. This gives an 8-bit cause vector, so the mask truncation at bit 8 and the highest error strobe can be seen through ordinary register reads. It also makes the soft-reset window short enough to count exactly. The timeout is programmed with small limits at divider exponents 0 and 1. This places the expiry edge at 3 and at 8 cycles after start, so the edge before expiry and the expiry edge itself are both sampled.

// File: rtl/scaler_ctrl.sv
module scaler_ctrl #(
  parameter int NUM_ERR    = 24,
  parameter int RST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               frame_done,
  input  logic [NUM_ERR-1:0] err_pulse,
  output logic               frame_start,
  output logic               busy,
  output logic               irq
);
  localparam int NC = NUM_ERR + 2;
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] rst_cnt;
  logic [NC-1:0] en_q, stat_q;
  logic          tmo_en;
  logic [15:0]   tmo_val, pre, cnt;
  logic [3:0]    tmo_div;

  wire resetting = rst_cnt != '0;
  wire wr_ctrl   = bus_wr && bus_addr == 2'd0;
  wire wr_en     = bus_wr && bus_addr == 2'd1;
  wire wr_stat   = bus_wr && bus_addr == 2'd2;
  wire wr_tmo    = bus_wr && bus_addr == 2'd3;
  wire go_rst    = wr_ctrl && bus_wdata[1];
  wire go_start  = wr_ctrl && bus_wdata[0] && !bus_wdata[1] && !busy && !resetting;
  wire tick      = busy && tmo_en && pre == ((16'd1 << tmo_div) - 16'd1);
  wire expire    = tick && cnt == tmo_val;
  wire done      = busy && frame_done;

  wire [NC-1:0] set_v = {err_pulse, expire, done};
  wire [NC-1:0] clr_v = wr_stat ? bus_wdata[NC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt     <= '0;
      busy        <= 1'b0;
      frame_start <= 1'b0;
      en_q        <= '0;
      stat_q      <= '0;
      tmo_en      <= 1'b1;
      tmo_val     <= 16'hFFFF;
      tmo_div     <= 4'hF;
      pre         <= '0;
      cnt         <= '0;
    end else begin
      frame_start <= go_start;

      if (go_rst)         rst_cnt <= RW'(RST_CYCLES);
      else if (resetting) rst_cnt <= rst_cnt - 1'b1;

      if (go_rst || done || expire) busy <= 1'b0;
      else if (go_start)            busy <= 1'b1;

      if (!busy || go_rst) begin
        pre <= '0;
        cnt <= '0;
      end else if (tmo_en) begin
        if (tick) begin
          pre <= '0;
          cnt <= cnt + 16'd1;
        end else begin
          pre <= pre + 16'd1;
        end
      end

      if (go_rst || resetting) en_q <= '0;
      else if (wr_en)          en_q <= bus_wdata[NC-1:0];

      if (go_rst || resetting) stat_q <= '0;
      else                     stat_q <= (stat_q & ~clr_v) | set_v;

      if (wr_tmo) begin
        tmo_en  <= bus_wdata[31];
        tmo_div <= bus_wdata[19:16];
        tmo_val <= bus_wdata[15:0];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {30'd0, resetting, busy};
      2'd1:    bus_rdata = 32'(en_q);
      2'd2:    bus_rdata = 32'(stat_q);
      default: bus_rdata = {tmo_en, 11'd0, tmo_div, tmo_val};
    endcase
  end

  assign irq = |(stat_q & en_q);
endmodule

// File: rtl/scaler_ctrl_chk.sv
module scaler_ctrl_chk #(
  parameter int NUM_ERR = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 frame_start,
  input logic                 frame_done,
  input logic [NUM_ERR-1:0]   err_pulse,
  input logic                 resetting,
  input logic [NUM_ERR+1:0]   stat,
  input logic [NUM_ERR+1:0]   en
);
  // R4
  start_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R4
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> busy && !$past(busy));

  // R5
  done_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && frame_done |=> !busy);

  // R2
  reset_holds_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> !busy && stat == '0);

  // R3
  en_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> en == '0);

  // R6
  err_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) && !resetting |=> (|stat[NUM_ERR+1:2]) || resetting);

  // R9
  timeout_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(busy) && !busy);
endmodule

bind scaler_ctrl scaler_ctrl_chk #(.NUM_ERR(NUM_ERR)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .frame_start(frame_start),
  .frame_done(frame_done), .err_pulse(err_pulse), .resetting(resetting),
  .stat(stat_q), .en(en_q)
);

// File: tb/sim_scaler_ctrl.sv
`timescale 1ns/1ps
module sim_scaler_ctrl;
  localparam int NE = 6;
  localparam int RC = 5;

  logic clk = 0, rst_n = 0, bus_wr = 0, frame_done = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NE-1:0] err_pulse = 0;
  logic frame_start, busy, irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  scaler_ctrl #(.NUM_ERR(NE), .RST_CYCLES(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
    .err_pulse(err_pulse), .frame_start(frame_start), .busy(busy), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 pending", v, 0);
    rd(3, v); chk("R1 timeout setup", v, 32'h800F_FFFF);
    chk("R1 outputs", {irq, busy, frame_start}, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(1, 32'h01); wr(0, 1); pulse_done();
    rd(2, v); chk("R5 pending before reset", v, 1);
    wr(0, 1);
    wr(0, 2);
    rd(0, v); chk("R2 reset in progress, frame ended", v, 2);
    repeat (RC - 1) @(negedge clk);
    rd(0, v); chk("R2 still resetting last cycle", v, 2);
    @(negedge clk);
    rd(0, v); chk("R2 reset self-clears", v, 0);
    rd(1, v); chk("R2 mask cleared", v, 0);
    rd(2, v); chk("R2 pending cleared", v, 0);
  endtask

  task automatic t_en_readback();
    logic [31:0] v;
    wr(0, 2);
    wr(1, 32'hFF);
    rd(1, v); chk("R3 mask write ignored in reset", v, 0);
    repeat (RC) @(negedge clk);
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R3 mask readback truncated", v, 32'hFF);
    wr(1, 32'h5A);
    rd(1, v); chk("R3 mask readback", v, 32'h5A);
  endtask

  task automatic t_start_done();
    logic [31:0] v;
    wr(0, 1);
    chk("R4 start pulse", frame_start, 1);
    rd(0, v); chk("R4 busy", v, 1);
    @(negedge clk);
    chk("R4 pulse one cycle", frame_start, 0);
    wr(0, 1);
    chk("R4 start while busy ignored", frame_start, 0);
    pulse_done();
    rd(0, v); chk("R5 done clears busy", v, 0);
    rd(2, v); chk("R5 frame-end set", v, 1);
    wr(2, 1);
    rd(2, v); chk("R7 frame-end cleared", v, 0);
    pulse_done();
    rd(2, v); chk("R5 done while idle ignored", v, 0);
  endtask

  task automatic t_errors_w1c();
    logic [31:0] v;
    wr(0, 1);
    @(negedge clk); err_pulse = 6'b000101;
    @(negedge clk); err_pulse = 0;
    rd(2, v); chk("R6 error causes latched", v, 32'h14);
    chk("R6 frame continues", busy, 1);
    @(negedge clk); err_pulse = 6'b100000;
    @(negedge clk); err_pulse = 0;
    rd(2, v); chk("R6 top error cause", v, 32'h94);
    wr(2, 32'h84);
    rd(2, v); chk("R7 partial clear", v, 32'h10);
    @(negedge clk);
    bus_wr = 1; bus_addr = 2; bus_wdata = 32'h10; err_pulse = 6'b000100;
    @(negedge clk);
    bus_wr = 0; err_pulse = 0;
    rd(2, v); chk("R7 set wins over clear", v, 32'h10);
    pulse_done();
    rd(2, v); chk("R5 frame-end with errors", v, 32'h11);
    wr(2, 32'hFF);
    rd(2, v); chk("R7 clear all", v, 0);
  endtask

  task automatic t_irq_mask();
    wr(0, 1); pulse_done();
    wr(1, 32'hFF);
    chk("R8 irq enabled cause", irq, 1);
    wr(1, 0);
    chk("R8 zero mask", irq, 0);
    wr(1, 32'h02);
    chk("R8 other cause enabled only", irq, 0);
    wr(1, 32'h01);
    chk("R8 matching cause", irq, 1);
    wr(2, 1);
    chk("R8 cleared", irq, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    wr(3, 32'h8001_0003);
    wr(0, 1);
    repeat (7) @(negedge clk);
    rd(2, v); chk("R9 no timeout before edge 8", v, 0);
    chk("R9 busy before expiry", busy, 1);
    @(negedge clk);
    rd(2, v); chk("R9 timeout at edge 8", v, 2);
    chk("R9 timeout ends frame", busy, 0);
    wr(2, 32'hFF);
    wr(3, 32'h8000_0002);
    wr(0, 1);
    repeat (2) @(negedge clk);
    rd(2, v); chk("R9 div0 no timeout at edge 2", v, 0);
    @(negedge clk);
    rd(2, v); chk("R9 div0 timeout at edge 3", v, 2);
    wr(2, 32'hFF);
    wr(3, 32'h8001_0003);
    wr(0, 1);
    repeat (3) @(negedge clk);
    pulse_done();
    repeat (10) @(negedge clk);
    rd(2, v); chk("R9 early finish, no timeout", v, 1);
    wr(2, 32'hFF);
  endtask

  task automatic t_timeout_disabled();
    logic [31:0] v;
    wr(3, 32'h0001_0003);
    wr(0, 1);
    repeat (20) @(negedge clk);
    rd(2, v); chk("R10 disabled timer silent", v, 0);
    chk("R10 still busy", busy, 1);
    pulse_done();
    rd(2, v); chk("R10 frame ends normally", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_soft_reset();
    t_en_readback();
    t_start_done();
    t_errors_w1c();
    t_irq_mask();
    t_timeout();
    t_timeout_disabled();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule